// File: doc/BRIEF.md
# Hall-synchronised sine modulation sequencer

This block turns three clean Hall position bits and a direction bit into drive commands for a three-phase brushless motor. At low speed it gives six square-wave commutation gates, decoded straight from the Hall state, with one phase pulled high and one pulled low. Above a speed threshold it switches to sinusoidal drive. In that mode it outputs one modulation word per phase, which an external triangle-carrier comparator turns into PWM.

The block counts system clock cycles between consecutive Hall transitions. Each transition marks 60 electrical degrees. Each 60-degree segment is split into 32 waveform steps, and each step lasts one thirty-second of the interval just measured. A new Hall edge always starts the segment again at step 0. If the segment runs out before the next edge arrives, the steps start over at the same width. In each segment one phase is held at the low rail and the other two carry the modulation. This is two-phase modulation, which keeps switching losses low. The carrier, the comparator, the dead time and the analog front end are outside this block.

Top module: `hall_sine_seq`

## Requirements
- R1: While `rst` is high, and after it is released with `hall_i` = 000, all modulation words are 0, `gate_hi_o`/`gate_lo_o` are 000 and `sine_mode_o` is 0.
- R2: The Hall code is {C,B,A}. The forward sequence 001, 011, 010, 110, 100, 101 maps to sectors 0 to 5. Gate bit 0 is phase A, bit 1 is B and bit 2 is C. In square mode with `dir_i` = 0, the phases driven high/low for each sector are: s0 C/B, s1 A/B, s2 A/C, s3 B/C, s4 B/A, s5 C/A. Outputs follow a new code one clock edge after it is sampled.
- R3: With `dir_i` = 1, the block uses sector (s+3) mod 6 in place of s. This swaps the high and low phase of every square-mode sector.
- R4: Hall codes 000 and 111 force every output to zero and the mode to square. The next valid edge is treated as the first edge after reset.
- R5: At each Hall edge, the mode becomes sinusoidal if the interval since the previous edge is below `SINE_LIMIT` clocks, and square otherwise. The mode changes only at Hall edges, and the first edge after reset is always square.
- R6: The interval counter stops at 2^`CNT_W`-1 and does not wrap. A gap longer than that reads as the maximum interval.
- R7: The step width is the measured interval shifted right by 5, with a width of 0 treated as 1. The step index k advances once per width.
- R8: After step 31 the index returns to 0 and continues at the same width until an edge arrives.
- R9: Every Hall edge resets the step index to 0, even when fewer than 32 steps have run.
- R10: In sine mode, with full scale S = 2^`AMP_W`-1, j = k and phase p (A=0, B=1, C=2) using shape (s-2p) mod 6, each word is within 2 LSB of round(S·sin x). The angle x is 60j/32 degrees for shape 0, 60+60j/32 for shapes 1 and 2, and 60-60j/32 for shape 3. Shapes 4 and 5 give 0.
- R11: With `dir_i` = 1 in sine mode, the sector is (s+3) mod 6 and j = 32-k, so the waveform runs backward through each segment.
- R12: In square mode all modulation words are 0. In sine mode both gate vectors are 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hall_i | input | 3 | Debounced Hall bits {C,B,A} |
| dir_i | input | 1 | 0 forward, 1 reverse |
| mod_a_o | output | AMP_W | Phase A modulation word |
| mod_b_o | output | AMP_W | Phase B modulation word |
| mod_c_o | output | AMP_W | Phase C modulation word |
| sine_mode_o | output | 1 | 1 = sinusoidal drive, 0 = square commutation |
| gate_hi_o | output | 3 | Square-mode high-side gates, bit 0 = A |
| gate_lo_o | output | 3 | Square-mode low-side gates, bit 0 = A |

## Verification
The Hall sequence is stepped forward at a steady spacing. This separates the square first segment from the sine segments that follow and checks the step width against each measured interval. A short segment followed by a long one checks that an edge cuts a segment short (restart) and that a long segment wraps the index several times. Reverse runs, invalid codes, one gap longer than the counter range and one gap just above the threshold separate the direction mapping, forced shutdown, saturation (a wrapping counter would wrongly enter sine mode) and the mode threshold.

// File: rtl/hsq_pkg.sv
package hsq_pkg;

    localparam int STEP_BITS = 5;
    localparam int STEPS     = 1 << STEP_BITS;

    typedef enum logic [1:0] {
        SH_RISE,
        SH_CREST,
        SH_FALL,
        SH_FLAT
    } shape_e;

    typedef struct packed {
        logic       valid;
        logic [2:0] sector;
    } hall_pos_t;

    // Forward electrical order of the Hall code {C,B,A}.
    function automatic hall_pos_t decode_hall(input logic [2:0] code);
        hall_pos_t r;
        r.valid = 1'b1;
        case (code)
            3'b001:  r.sector = 3'd0;
            3'b011:  r.sector = 3'd1;
            3'b010:  r.sector = 3'd2;
            3'b110:  r.sector = 3'd3;
            3'b100:  r.sector = 3'd4;
            3'b101:  r.sector = 3'd5;
            default: begin
                r.valid  = 1'b0;
                r.sector = 3'd0;
            end
        endcase
        return r;
    endfunction

    function automatic logic [2:0] opposite_sector(input logic [2:0] s);
        return (s >= 3'd3) ? s - 3'd3 : s + 3'd3;
    endfunction

    // Shape a phase carries in a sector; phases lag by two sectors each.
    function automatic shape_e phase_shape(input logic [2:0] s, input int p);
        int idx;
        idx = (int'(s) + 6 - 2 * p) % 6;
        case (idx)
            0:       return SH_RISE;
            1, 2:    return SH_CREST;
            3:       return SH_FALL;
            default: return SH_FLAT;
        endcase
    endfunction

    // Rational sine approximation; angle given in eighths of a degree (0..1440).
    function automatic longint sine_eighths(input longint x8, input longint full);
        longint u;
        u = x8 * (64'sd1440 - x8);
        return (64'sd4 * u * full) / (64'sd2592000 - u);
    endfunction

endpackage

// File: rtl/hsq_interval.sv
module hsq_interval
    import hsq_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int SINE_LIMIT = 6720,
    localparam int WID_W     = CNT_W - STEP_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             edge_i,
    input  logic             invalid_i,
    output logic [WID_W-1:0] width_o,
    output logic             sine_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W:0]   LIMIT   = (CNT_W+1)'(SINE_LIMIT);

    logic [CNT_W-1:0] ivl_q;
    logic [CNT_W-1:0] span;

    assign span = (ivl_q == CNT_MAX) ? CNT_MAX : ivl_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            ivl_q   <= CNT_MAX;
            width_o <= '0;
            sine_o  <= 1'b0;
        end else if (edge_i) begin
            if (invalid_i) begin
                ivl_q  <= CNT_MAX;
                sine_o <= 1'b0;
            end else begin
                ivl_q   <= '0;
                width_o <= span[CNT_W-1:STEP_BITS];
                sine_o  <= ({1'b0, span} < LIMIT);
            end
        end else begin
            ivl_q <= span;
        end
    end

endmodule

// File: rtl/hsq_stepper.sv
module hsq_stepper
    import hsq_pkg::*;
#(
    parameter int WID_W = 11
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 edge_i,
    input  logic [WID_W-1:0]     width_i,
    output logic [STEP_BITS-1:0] idx_o
);

    logic [WID_W-1:0] sub_q;
    logic             last;

    // A width of zero steps every cycle.
    assign last = ({1'b0, sub_q} + 1'b1) >= {1'b0, width_i};

    always_ff @(posedge clk) begin
        if (rst || edge_i) begin
            sub_q <= '0;
            idx_o <= '0;
        end else if (last) begin
            sub_q <= '0;
            idx_o <= idx_o + 1'b1;
        end else begin
            sub_q <= sub_q + 1'b1;
        end
    end

endmodule

// File: rtl/hsq_shaper.sv
module hsq_shaper
    import hsq_pkg::*;
#(
    parameter int AMP_W = 8
) (
    input  logic                      valid_i,
    input  logic [2:0]                sector_i,
    input  logic                      dir_i,
    input  logic                      sine_i,
    input  logic [STEP_BITS-1:0]      idx_i,
    output logic [2:0][AMP_W-1:0]     mod_o,
    output logic [2:0]                gate_hi_o,
    output logic [2:0]                gate_lo_o
);

    localparam longint FULL = (longint'(1) << AMP_W) - 1;
    localparam logic [STEP_BITS:0] SPAN = (STEP_BITS+1)'(STEPS);

    logic [AMP_W-1:0] rise_tbl  [STEPS+1];
    logic [AMP_W-1:0] crest_tbl [STEPS+1];

    for (genvar g = 0; g <= STEPS; g++) begin : g_tbl
        localparam longint X8 = (longint'(480) * g) / STEPS;
        assign rise_tbl[g]  = AMP_W'(sine_eighths(X8, FULL));
        assign crest_tbl[g] = AMP_W'(sine_eighths(X8 + 480, FULL));
    end

    logic [2:0]         eff_sec;
    logic [STEP_BITS:0] j;
    logic [STEP_BITS:0] jr;
    shape_e             shp;
    logic [AMP_W-1:0]   w;

    always_comb begin
        eff_sec   = dir_i ? opposite_sector(sector_i) : sector_i;
        j         = dir_i ? SPAN - {1'b0, idx_i} : {1'b0, idx_i};
        jr        = SPAN - j;
        mod_o     = '0;
        gate_hi_o = '0;
        gate_lo_o = '0;
        shp       = SH_FLAT;
        w         = '0;
        for (int p = 0; p < 3; p++) begin
            shp = phase_shape(eff_sec, p);
            case (shp)
                SH_RISE:  w = rise_tbl[j];
                SH_CREST: w = crest_tbl[j];
                SH_FALL:  w = rise_tbl[jr];
                default:  w = '0;
            endcase
            mod_o[p]     = (valid_i && sine_i) ? w : '0;
            gate_hi_o[p] = valid_i && !sine_i && (shp == SH_CREST);
            gate_lo_o[p] = valid_i && !sine_i && (shp == SH_FLAT);
        end
    end

endmodule

// File: rtl/hall_sine_seq.sv
module hall_sine_seq
    import hsq_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int AMP_W      = 8,
    parameter int SINE_LIMIT = 6720
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       hall_i,
    input  logic             dir_i,
    output logic [AMP_W-1:0] mod_a_o,
    output logic [AMP_W-1:0] mod_b_o,
    output logic [AMP_W-1:0] mod_c_o,
    output logic             sine_mode_o,
    output logic [2:0]       gate_hi_o,
    output logic [2:0]       gate_lo_o
);

    localparam int WID_W = CNT_W - STEP_BITS;

    logic [2:0]            hall_q;
    logic                  hall_edge;
    hall_pos_t             new_pos;
    hall_pos_t             cur_pos;
    logic [WID_W-1:0]      step_width;
    logic [STEP_BITS-1:0]  step_idx;
    logic [2:0][AMP_W-1:0] mod_w;

    always_ff @(posedge clk) begin
        if (rst) hall_q <= 3'b000;
        else     hall_q <= hall_i;
    end

    assign hall_edge = (hall_i != hall_q);
    assign new_pos   = decode_hall(hall_i);
    assign cur_pos   = decode_hall(hall_q);

    hsq_interval #(.CNT_W(CNT_W), .SINE_LIMIT(SINE_LIMIT)) u_interval (
        .clk       (clk),
        .rst       (rst),
        .edge_i    (hall_edge),
        .invalid_i (!new_pos.valid),
        .width_o   (step_width),
        .sine_o    (sine_mode_o)
    );

    hsq_stepper #(.WID_W(WID_W)) u_stepper (
        .clk     (clk),
        .rst     (rst),
        .edge_i  (hall_edge),
        .width_i (step_width),
        .idx_o   (step_idx)
    );

    hsq_shaper #(.AMP_W(AMP_W)) u_shaper (
        .valid_i   (cur_pos.valid),
        .sector_i  (cur_pos.sector),
        .dir_i     (dir_i),
        .sine_i    (sine_mode_o),
        .idx_i     (step_idx),
        .mod_o     (mod_w),
        .gate_hi_o (gate_hi_o),
        .gate_lo_o (gate_lo_o)
    );

    assign mod_a_o = mod_w[0];
    assign mod_b_o = mod_w[1];
    assign mod_c_o = mod_w[2];

endmodule

// File: rtl/hsq_checker.sv
module hsq_checker #(
    parameter int AMP_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       hall_i,
    input logic [2:0]       hall_q,
    input logic [4:0]       step_idx,
    input logic [AMP_W-1:0] mod_a,
    input logic [AMP_W-1:0] mod_b,
    input logic [AMP_W-1:0] mod_c,
    input logic             sine_mode,
    input logic [2:0]       gate_hi,
    input logic [2:0]       gate_lo
);

    p_gate_excl_r2: assert property (@(posedge clk) disable iff (rst)
        ((gate_hi & gate_lo) == 3'b000) && ($countones(gate_hi) <= 1) && ($countones(gate_lo) <= 1));

    p_invalid_off_r4: assert property (@(posedge clk) disable iff (rst)
        (hall_q == 3'b000 || hall_q == 3'b111) |->
        (mod_a == '0 && mod_b == '0 && mod_c == '0 && gate_hi == 3'b000 && gate_lo == 3'b000));

    p_mode_at_edge_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(sine_mode) |-> $past(hall_i != hall_q));

    p_restart_r9: assert property (@(posedge clk) disable iff (rst)
        (hall_i != hall_q) |=> (step_idx == 5'd0));

    p_one_flat_r10: assert property (@(posedge clk) disable iff (rst)
        sine_mode |-> (mod_a == '0 || mod_b == '0 || mod_c == '0));

    p_square_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        !sine_mode |-> (mod_a == '0 && mod_b == '0 && mod_c == '0));

    p_sine_gates_off_r12: assert property (@(posedge clk) disable iff (rst)
        sine_mode |-> (gate_hi == 3'b000 && gate_lo == 3'b000));

endmodule

bind hall_sine_seq hsq_checker #(.AMP_W(AMP_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .hall_i    (hall_i),
    .hall_q    (hall_q),
    .step_idx  (step_idx),
    .mod_a     (mod_a_o),
    .mod_b     (mod_b_o),
    .mod_c     (mod_c_o),
    .sine_mode (sine_mode_o),
    .gate_hi   (gate_hi_o),
    .gate_lo   (gate_lo_o)
);

// File: tb/hall_sine_seq_bench.sv
`timescale 1ns/1ps
module hall_sine_seq_bench;

    localparam int CNT_W = 12;
    localparam int AMP_W = 8;
    localparam int LIMIT = 2000;
    localparam int CMAX  = (1 << CNT_W) - 1;
    localparam int FS    = (1 << AMP_W) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [2:0]       hall = 3'b000;
    logic             dir = 1'b0;
    logic [AMP_W-1:0] mod_a, mod_b, mod_c;
    logic             sine;
    logic [2:0]       ghi, glo;

    hall_sine_seq #(.CNT_W(CNT_W), .AMP_W(AMP_W), .SINE_LIMIT(LIMIT)) u_hall_sine_seq (
        .clk         (clk),
        .rst         (rst),
        .hall_i      (hall),
        .dir_i       (dir),
        .mod_a_o     (mod_a),
        .mod_b_o     (mod_b),
        .mod_c_o     (mod_c),
        .sine_mode_o (sine),
        .gate_hi_o   (ghi),
        .gate_lo_o   (glo)
    );

    always #5 clk = ~clk;

    typedef struct {
        int    cyc;
        int    w [3];
        int    sine;
        int    hi;
        int    lo;
        string tag;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    n_checks = 0;
    int    n_err = 0;
    int    last_edge = -1;
    bit    done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic cmp(input string tag, input string what, input int act, input int expv, input int tol);
        int d;
        n_checks++;
        d = (act > expv) ? act - expv : expv - act;
        if (d > tol) begin
            n_err++;
            $display("FAIL %s %s actual %0d expected %0d (cycle %0d)", tag, what, act, expv, cyc);
        end
    endtask

    function automatic int sector_of(input logic [2:0] code);
        case (code)
            3'b001: return 0;
            3'b011: return 1;
            3'b010: return 2;
            3'b110: return 3;
            3'b100: return 4;
            3'b101: return 5;
            default: return -1;
        endcase
    endfunction

    function automatic int wave(input int shape, input int j);
        real deg;
        case (shape)
            0:       deg = 60.0 * j / 32.0;
            1, 2:    deg = 60.0 + 60.0 * j / 32.0;
            3:       deg = 60.0 - 60.0 * j / 32.0;
            default: return 0;
        endcase
        return $rtoi(FS * $sin(deg * 3.14159265358979 / 180.0) + 0.5);
    endfunction

    function automatic item_t model(input logic [2:0] code, input logic d, input bit sn, input int k);
        item_t it;
        int s, es, j, sh;
        s = sector_of(code);
        it.sine = 0; it.hi = 0; it.lo = 0;
        for (int p = 0; p < 3; p++) it.w[p] = 0;
        if (s < 0) return it;
        it.sine = sn;
        es = d ? (s + 3) % 6 : s;
        j  = d ? 32 - k : k;
        for (int p = 0; p < 3; p++) begin
            sh = (es + 6 - 2 * p) % 6;
            if (sn) it.w[p] = wave(sh, j);
            else begin
                if (sh == 1 || sh == 2) it.hi |= (1 << p);
                if (sh == 4 || sh == 5) it.lo |= (1 << p);
            end
        end
        return it;
    endfunction

    // Driver: applies a code at a falling edge and queues the expected outputs.
    task automatic apply(input logic [2:0] code, input logic d, input int len, input string tag);
        int e, n, w, eff;
        bit sn;
        item_t it;
        hall = code;
        dir  = d;
        e    = cyc + 1;
        if (sector_of(code) < 0) begin
            sn = 0; eff = 1; last_edge = -1;
        end else begin
            n  = (last_edge < 0) ? CMAX : ((e - last_edge) > CMAX ? CMAX : e - last_edge);
            sn = (n < LIMIT);
            w  = n >> 5;
            eff = (w == 0) ? 1 : w;
            last_edge = e;
        end
        for (int m = 0; m <= len - 2; m++) begin
            if (sn ? (m % eff == 0 || m % eff == eff - 1) : (m == 0 || m == len / 2)) begin
                it = model(code, d, sn, (m / eff) % 32);
                it.cyc = e + m;
                it.tag = tag;
                q.push_back(it);
            end
        end
        repeat (len) @(negedge clk);
    endtask

    // Monitor: compares queued expectations shortly after the falling edge.
    always @(negedge clk) begin
        item_t it;
        #1;
        while (q.size() > 0 && q[0].cyc <= cyc) begin
            it = q.pop_front();
            cmp(it.tag, "cycle", cyc, it.cyc, 0);
            cmp(it.tag, "mode", int'(sine), it.sine, 0);
            cmp(it.tag, "mod_a", int'(mod_a), it.w[0], 2);
            cmp(it.tag, "mod_b", int'(mod_b), it.w[1], 2);
            cmp(it.tag, "mod_c", int'(mod_c), it.w[2], 2);
            cmp(it.tag, "gate_hi", int'(ghi), it.hi, 0);
            cmp(it.tag, "gate_lo", int'(glo), it.lo, 0);
        end
    end

    task automatic check_idle(input string tag);
        cmp(tag, "mode", int'(sine), 0, 0);
        cmp(tag, "mods", int'(mod_a) + int'(mod_b) + int'(mod_c), 0, 0);
        cmp(tag, "gates", int'({ghi, glo}), 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 check_idle("R1");
        @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        #1 check_idle("R1");
        @(negedge clk);

        // Forward rotation: first segment square, then sine at steady speed.
        apply(3'b001, 0, 320, "R2");
        apply(3'b011, 0, 320, "R7");
        apply(3'b010, 0, 320, "R7");
        apply(3'b110, 0, 320, "R10");
        apply(3'b100, 0, 320, "R10");
        apply(3'b101, 0, 320, "R12");
        // Short segment then long: wrap of the index, then cut-short restarts.
        apply(3'b001, 0, 160, "R7");
        apply(3'b011, 0, 640, "R8");
        apply(3'b010, 0, 200, "R9");
        apply(3'b110, 0, 200, "R9");
        // Reverse rotation.
        apply(3'b010, 1, 300, "R11");
        apply(3'b011, 1, 300, "R11");
        apply(3'b001, 1, 300, "R11");
        apply(3'b101, 1, 3000, "R11");
        apply(3'b100, 1, 100, "R3");
        apply(3'b110, 1, 100, "R11");
        // Invalid codes.
        apply(3'b111, 0, 50, "R4");
        apply(3'b001, 0, 300, "R4");
        apply(3'b011, 0, 100, "R4");
        apply(3'b000, 0, 50, "R4");
        apply(3'b010, 0, 100, "R4");
        // Gap beyond the counter range must not wrap into sine mode.
        apply(3'b110, 0, 200, "R5");
        apply(3'b100, 0, 6000, "R10");
        apply(3'b101, 0, 200, "R6");
        apply(3'b001, 0, 100, "R5");
        // Gap just above the threshold.
        apply(3'b011, 0, 2500, "R10");
        apply(3'b010, 0, 100, "R5");
        repeat (3) @(negedge clk);
        cmp("R5", "queue", q.size(), 0, 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            n_err++;
            $display("FAIL all watchdog actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

endmodule